// File: doc/BRIEF.md
# Programmable Word CRC-32 Engine

This peripheral folds 32-bit words into a running 32-bit cyclic redundancy check. A host reaches it over a simple single-cycle register bus. The bus carries a byte address, a write enable, write data, byte strobes and combinational read data. The generator polynomial and the seed can both be changed. A write to the control word can restart the running value from the seed. The same control word can also select a mirrored mode: each input word is bit-reversed before it enters a normal MSB-first engine, and the running value is shown bit-reversed on reads. In this mode the engine produces the reflected CRC-32 and CRC-32C results.

A typical session programs the seed and the polynomial, then writes the control word with its restart bit set. After that the host streams words into the data register and reads the data register at any point to get the partial result. Bytes left over at the end of a message and any final complement are handled in software.

Top module: `wordcrc_unit`

## Requirements
- R1: After system reset, reading offset 0x00 returns 0xFFFFFFFF, 0x08 returns 0, 0x10 (seed) returns 0xFFFFFFFF and 0x14 (polynomial) returns 0x04C11DB7.
- R2: With mirrored mode off, a write to 0x00 with all four strobes set replaces the running value with the MSB-first CRC update of that word: XOR the word into the value, then apply 32 steps of shift-left, XOR-ing in the polynomial whenever the bit shifted out was 1.
- R3: With control bits 7:5 all set (mirrored mode), the data-register value equals the reflected CRC: XOR the word into the value, then apply 32 steps of shift-right, XOR-ing in the bit-reversed polynomial whenever the bit shifted out was 1. With polynomial 0x04C11DB7 this is CRC-32; with 0x1EDC6F41 it is CRC-32C before its complement.
- R4: A control write with byte 0 strobed and data bit 0 set loads the running value from the seed register. Bit 0 always reads 0, bits 4:1 and 31:8 read 0, and bits 7:5 read back as written. Any value of bits 7:5 other than all ones leaves mirrored mode off.
- R5: Reading 0x00 never changes the running value. A read on the same cycle as a data write returns the value from before that write.
- R6: Data writes on consecutive cycles are each folded in order, with no lost word.
- R7: Seed, polynomial and control writes update only the strobed bytes; the control bits sit in byte 0. A data write with any strobe clear is ignored.
- R8: Any other byte offset, including a misaligned one, reads 0, and writes to it change no register.
- R9: With mirrored mode on, the data register shows the bit reversal of the internal value, so right after a restart it reads as the reversed seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_we | input | 1 | Write enable for this cycle |
| bus_be | input | 4 | Byte strobes for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A data write and a read of the data register can happen on the same cycle, because the bus has one address and the read path is combinational. The bench creates this case by driving a write to offset 0x00 and checking the read data at the falling edge of that same cycle, where it must still show the value from before the write. A read on the next cycle must then show the folded value. The bench runs this in both plain and mirrored modes. It also checks a restart write against a later data write, to confirm that the seed and the update are applied in the right order.

// File: rtl/crcw_pkg.sv
package crcw_pkg;
    localparam int CRC_W  = 32;
    localparam int NBYTES = CRC_W / 8;
    localparam int REV_LO = 5;
    localparam int REV_HI = 7;
    localparam int REV_W  = REV_HI - REV_LO + 1;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_SEED = 8'h10;
    localparam logic [7:0] OFS_POLY = 8'h14;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] seed;
        logic [CRC_W-1:0] poly;
        logic [REV_W-1:0] rev;
    } crcw_state_t;

    function automatic logic [CRC_W-1:0] byte_merge(
        input logic [CRC_W-1:0]  old_v,
        input logic [CRC_W-1:0]  new_v,
        input logic [NBYTES-1:0] strobe
    );
        logic [CRC_W-1:0] res;
        res = old_v;
        for (int b = 0; b < NBYTES; b++) begin
            if (strobe[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/crcw_mirror.sv
module crcw_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/crcw_fold.sv
module crcw_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] word_in,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < W; i++) begin : g_step
        logic fb;
        assign fb = stage[i][W-1] ^ word_in[W-1-i];
        assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/wordcrc_unit.sv
module wordcrc_unit #(
    parameter int          ADDR_W    = 5,
    parameter logic [31:0] SEED_RST  = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST  = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    import crcw_pkg::*;

    crcw_state_t st_d, st_q;

    logic sel_data, sel_ctrl, sel_seed, sel_poly, mapped;
    logic rev_on;
    logic [CRC_W-1:0] word_rev, word_feed, fold_out, crc_rev, crc_view;

    assign sel_data = (bus_addr == OFS_DATA[ADDR_W-1:0]);
    assign sel_ctrl = (bus_addr == OFS_CTRL[ADDR_W-1:0]);
    assign sel_seed = (bus_addr == OFS_SEED[ADDR_W-1:0]);
    assign sel_poly = (bus_addr == OFS_POLY[ADDR_W-1:0]);
    assign mapped   = sel_data | sel_ctrl | sel_seed | sel_poly;
    assign rev_on   = &st_q.rev;

    crcw_mirror #(.W(CRC_W)) u_in_mirror (
        .din  (bus_wdata),
        .dout (word_rev)
    );

    assign word_feed = rev_on ? word_rev : bus_wdata;

    crcw_fold #(.W(CRC_W)) u_fold (
        .crc_in  (st_q.crc),
        .word_in (word_feed),
        .poly    (st_q.poly),
        .crc_out (fold_out)
    );

    crcw_mirror #(.W(CRC_W)) u_out_mirror (
        .din  (st_q.crc),
        .dout (crc_rev)
    );

    assign crc_view = rev_on ? crc_rev : st_q.crc;

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (sel_data && (&bus_be)) begin
                st_d.crc = fold_out;
            end
            if (sel_ctrl && bus_be[0]) begin
                st_d.rev = bus_wdata[REV_HI:REV_LO];
                if (bus_wdata[0]) st_d.crc = st_q.seed;
            end
            if (sel_seed) st_d.seed = byte_merge(st_q.seed, bus_wdata, bus_be);
            if (sel_poly) st_d.poly = byte_merge(st_q.poly, bus_wdata, bus_be);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.crc  <= SEED_RST;
            st_q.seed <= SEED_RST;
            st_q.poly <= POLY_RST;
            st_q.rev  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_data) bus_rdata = crc_view;
        if (sel_ctrl) bus_rdata[REV_HI:REV_LO] = st_q.rev;
        if (sel_seed) bus_rdata = st_q.seed;
        if (sel_poly) bus_rdata = st_q.poly;
    end

    // R4: restart loads the seed that was held at the write
    a_r4_restart_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_ctrl && bus_be[0] && bus_wdata[0]) |=> (st_q.crc == $past(st_q.seed)));

    // R4: restart bit and reserved control bits never read back
    a_r4_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> (bus_rdata[4:0] == 5'd0 && bus_rdata[31:8] == 24'd0));

    // R5: without a write the running value holds
    a_r5_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(st_q.crc));

    // R7: partial-strobe data write leaves the running value alone
    a_r7_partial_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_data && !(&bus_be)) |=> $stable(st_q.crc));

    // R8: writes to unmapped offsets touch nothing
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> $stable(st_q));

    // R8: unmapped offsets read zero
    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 32'd0));
endmodule

// File: tb/wordcrc_unit_bench.sv
module wordcrc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    wordcrc_unit u_wordcrc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_be    (be),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;
    logic        mon_en = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] m;

    // monitor: pops expected read values and compares away from the edge
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    function automatic logic [31:0] ref_msb(input logic [31:0] c, input logic [31:0] w,
                                            input logic [31:0] p);
        logic [31:0] r;
        r = c ^ w;
        for (int k = 0; k < 32; k++) r = r[31] ? ((r << 1) ^ p) : (r << 1);
        return r;
    endfunction

    function automatic logic [31:0] ref_lsb(input logic [31:0] c, input logic [31:0] w,
                                            input logic [31:0] rp);
        logic [31:0] r;
        r = c ^ w;
        for (int k = 0; k < 32; k++) r = r[0] ? ((r >> 1) ^ rp) : (r >> 1);
        return r;
    endfunction

    function automatic logic [31:0] brev(input logic [31:0] x);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[k] = x[31-k];
        return r;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        addr = a; we = 1'b1; be = b; wdata = d; mon_en = 1'b0;
        @(posedge clk); #1;
        we = 1'b0; be = 4'h0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
        addr = a; we = 1'b0; mon_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        mon_en = 1'b0;
    endtask

    task automatic wrrd(input logic [31:0] d, input logic [31:0] e, input string t);
        addr = 5'h00; we = 1'b1; be = 4'hF; wdata = d; mon_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        we = 1'b0; be = 4'h0; mon_en = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; we = 1'b0; be = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, 32'hFFFF_FFFF, "R1 data");
        rd(5'h08, 32'h0,         "R1 ctrl");
        rd(5'h10, 32'hFFFF_FFFF, "R1 seed");
        rd(5'h14, 32'h04C1_1DB7, "R1 poly");

        // R2 single fold, plain mode
        m = 32'hFFFF_FFFF;
        wr(5'h00, 32'hA5A5_F00F, 4'hF);
        m = ref_msb(m, 32'hA5A5_F00F, 32'h04C1_1DB7);
        rd(5'h00, m, "R2 single word");

        // R6 back-to-back words
        wr(5'h00, 32'h1234_5678, 4'hF);
        wr(5'h00, 32'hDEAD_BEEF, 4'hF);
        wr(5'h00, 32'h0000_0000, 4'hF);
        wr(5'h00, 32'hFFFF_FFFF, 4'hF);
        m = ref_msb(m, 32'h1234_5678, 32'h04C1_1DB7);
        m = ref_msb(m, 32'hDEAD_BEEF, 32'h04C1_1DB7);
        m = ref_msb(m, 32'h0000_0000, 32'h04C1_1DB7);
        m = ref_msb(m, 32'hFFFF_FFFF, 32'h04C1_1DB7);
        rd(5'h00, m, "R6 consecutive words");
        rd(5'h00, m, "R5 repeated read");

        // R4 restart
        wr(5'h08, 32'h0000_0001, 4'h1);
        rd(5'h00, 32'hFFFF_FFFF, "R4 restart loads seed");
        rd(5'h08, 32'h0,         "R4 restart bit reads 0");

        // R7 byte strobes
        wr(5'h10, 32'h0000_0000, 4'hF);
        wr(5'h10, 32'hAAAA_5555, 4'h3);
        rd(5'h10, 32'h0000_5555, "R7 seed strobes");
        wr(5'h14, 32'h1EDC_6F41, 4'hC);
        rd(5'h14, 32'h1EDC_1DB7, "R7 poly strobes");
        wr(5'h08, 32'h0000_0001, 4'h1);
        m = 32'h0000_5555;
        rd(5'h00, m, "R4 restart with new seed");
        wr(5'h00, 32'h1122_3344, 4'h7);
        rd(5'h00, m, "R7 partial data write ignored");
        wr(5'h00, 32'h1122_3344, 4'hF);
        m = ref_msb(m, 32'h1122_3344, 32'h1EDC_1DB7);
        rd(5'h00, m, "R2 fold with new poly");

        // R8 unmapped offsets
        wr(5'h04, 32'hDEAD_BEEF, 4'hF);
        wr(5'h0C, 32'hFFFF_FFFF, 4'hF);
        wr(5'h18, 32'h1234_5678, 4'hF);
        wr(5'h11, 32'h0000_0000, 4'hF);
        rd(5'h04, 32'h0, "R8 read 0x04");
        rd(5'h0C, 32'h0, "R8 read 0x0C");
        rd(5'h1C, 32'h0, "R8 read 0x1C");
        rd(5'h00, m,            "R8 data unchanged");
        rd(5'h10, 32'h0000_5555, "R8 seed unchanged");
        rd(5'h14, 32'h1EDC_1DB7, "R8 poly unchanged");
        rd(5'h08, 32'h0,         "R8 ctrl unchanged");

        // R5 write and read in one cycle, plain mode
        wrrd(32'hCAFE_F00D, m, "R5 same-cycle read old value");
        m = ref_msb(m, 32'hCAFE_F00D, 32'h1EDC_1DB7);
        rd(5'h00, m, "R5 next-cycle read new value");

        // R4 partial reverse bits keep plain mode
        wr(5'h08, 32'h0000_0061, 4'h1);
        rd(5'h08, 32'h0000_0060, "R4 bits 7:5 read back");
        rd(5'h00, 32'h0000_5555, "R4 partial bits not mirrored");

        // R9 mirrored view of the seed
        wr(5'h08, 32'h0000_00E1, 4'h1);
        rd(5'h08, 32'h0000_00E0, "R9 ctrl mirrored");
        rd(5'h00, 32'hAAAA_0000, "R9 reversed seed view");

        // R7 control write without byte 0 strobe
        wr(5'h08, 32'h0000_0000, 4'hE);
        rd(5'h08, 32'h0000_00E0, "R7 ctrl unstrobed ignored");

        // R3 reflected CRC-32
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        wr(5'h14, 32'h04C1_1DB7, 4'hF);
        wr(5'h08, 32'h0000_00E1, 4'h1);
        m = 32'hFFFF_FFFF;
        rd(5'h00, m, "R3 crc32 start");
        wr(5'h00, 32'h3433_3231, 4'hF);
        wr(5'h00, 32'h3837_3635, 4'hF);
        wr(5'h00, 32'h0000_0001, 4'hF);
        m = ref_lsb(m, 32'h3433_3231, 32'hEDB8_8320);
        m = ref_lsb(m, 32'h3837_3635, 32'hEDB8_8320);
        m = ref_lsb(m, 32'h0000_0001, 32'hEDB8_8320);
        rd(5'h00, m, "R3 crc32 result");
        wrrd(32'h8000_0000, m, "R5 same-cycle read old value mirrored");
        m = ref_lsb(m, 32'h8000_0000, 32'hEDB8_8320);
        rd(5'h00, m, "R3 crc32 after same-cycle write");

        // R3 reflected CRC-32C
        wr(5'h14, 32'h1EDC_6F41, 4'hF);
        wr(5'h08, 32'h0000_00E1, 4'h1);
        m = 32'hFFFF_FFFF;
        wr(5'h00, 32'h6463_6261, 4'hF);
        wr(5'h00, 32'h0F0F_F0F0, 4'hF);
        m = ref_lsb(m, 32'h6463_6261, 32'h82F6_3B78);
        m = ref_lsb(m, 32'h0F0F_F0F0, 32'h82F6_3B78);
        rd(5'h00, m, "R3 crc32c result");

        // restart followed immediately by a data write
        wr(5'h08, 32'h0000_00E1, 4'h1);
        wr(5'h00, 32'h5555_AAAA, 4'hF);
        m = ref_lsb(32'hFFFF_FFFF, 32'h5555_AAAA, 32'h82F6_3B78);
        rd(5'h00, m, "R4 restart then fold");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule